// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous byte-wide static RAM with a 15-bit address. The host hands over one request at a time as a single-cycle strobe carrying the address, the write data and a read/write flag. The controller then drives the RAM control pins: an active-low select, an active-high enable, an active-low write strobe and an active-low output enable. It also owns the direction of the shared data bus, which appears at the block edge as a split output, output-enable and input triple for an external pad. When an access finishes it raises a one-cycle completion pulse, and for reads it presents the captured byte.

Every analog timing limit of the RAM is a parameter in nanoseconds. Each is turned into a whole number of clock cycles by rounding up, with at least one cycle per phase. The controller sequences writes in three phases: a float phase with the write strobe low and the bus undriven, a drive phase, and a recovery phase with the strobe high. A read is a single access phase. A new request can start in the last cycle of the previous one, so writes, reads and mixed sequences can run back to back. A one-cycle bus turnaround is inserted whenever a read directly follows a write.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, mem_cs_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0. After reset, resp_done=0 and resp_rdata=0.
- R2: A read holds mem_cs_n=0, mem_ce=1, mem_we_n=1 and mem_oe_n=0 for max(ceil(T_AA_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)) cycles, which is 5 at the defaults. It captures mem_dq_i at the end of the last of these cycles and presents that byte on resp_rdata in the completion cycle.
- R3: A write holds mem_we_n=0, mem_cs_n=0, mem_ce=1 and mem_oe_n=1 for exactly Q+D cycles, with mem_addr unchanged throughout. Q=ceil(T_WLQZ_NS/CLK_NS) and D=max(ceil(T_DW_NS/CLK_NS), ceil(T_WP_NS/CLK_NS)-Q, ceil(T_AW_NS/CLK_NS)-Q), so the pulse is 5 cycles at the defaults. Every conversion rounds up and is at least 1.
- R4: mem_dq_oe is 1 only inside a write pulse and never while mem_oe_n=0. It rises after Q cycles of mem_we_n low (2 at the defaults), stays high for D cycles (3), and falls at the same edge at which mem_we_n rises. The write byte is held on mem_dq_o throughout.
- R5: Between two write pulses, mem_we_n returns high for at least max(ceil(T_WREC_NS/CLK_NS), ceil(T_WC_NS/CLK_NS)-Q-D) cycles (1 at the defaults). Falling edge to falling edge is at least ceil(T_WC_NS/CLK_NS) cycles.
- R6: A read accepted in the last cycle of a write first spends one cycle with mem_cs_n=0, mem_oe_n=1 and mem_dq_oe=0. Only then does mem_oe_n fall, so that read lasts one cycle longer.
- R7: A read accepted in the last cycle of a read keeps mem_cs_n and mem_oe_n low, changes only mem_addr, and counts the full access time again from the new address.
- R8: resp_done is high for exactly one cycle, the cycle after the last cycle of each access, once per accepted request. resp_rdata changes only when a read completes; writes leave it unchanged.
- R9: req_valid is acted on only while idle or in the last cycle of an access. A strobe at any other time is ignored: it causes no write, no change of mem_addr or mem_dq_o, and no extra resp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Single-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write byte |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 8 | Last byte read, held |
| mem_addr | output | 15 | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_ce | output | 1 | RAM enable, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_o | output | 8 | Byte driven toward the RAM |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_i | input | 8 | Byte returned from the RAM |

## Verification
The bench has a RAM model that returns the inverted byte until both the address-access and output-enable-access windows have elapsed. A read sampled even one cycle early therefore shows up as a data mismatch. Directed sequences cover isolated accesses, write-after-write, write-then-read and read-then-read issued exactly in the final cycle, as well as a strobe during a busy write. These separate the turnaround, recovery and access-restart paths from the plain idle start. A seeded random mix of reads and writes to a small set of aliased addresses, either back to back or with idle gaps, checks read-back data and the held read byte against a reference array. It also checks every write pulse for width, float delay, drive length and address stability.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WFLOAT,
        ST_WDRIVE,
        ST_WREC,
        ST_RTURN,
        ST_RACC
    } asram_st_e;

    // Nanoseconds to clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_rd_capture.sv
`timescale 1ns/1ps
module asram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cap_en) begin
            data_q <= din;
        end
    end

    assign dout = data_q;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 5,
    parameter int T_WP_NS   = 20,
    parameter int T_AW_NS   = 20,
    parameter int T_DW_NS   = 15,
    parameter int T_WREC_NS = 5,
    parameter int T_WC_NS   = 25,
    parameter int T_WLQZ_NS = 9,
    parameter int T_AA_NS   = 25,
    parameter int T_OE_NS   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_done,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    import asram_pkg::*;

    // Phase lengths in cycles
    localparam int C_QZ    = ns_to_cyc(T_WLQZ_NS, CLK_NS);
    localparam int C_DRV   = max2(ns_to_cyc(T_DW_NS, CLK_NS),
                                  max2(ns_to_cyc(T_WP_NS, CLK_NS) - C_QZ,
                                       ns_to_cyc(T_AW_NS, CLK_NS) - C_QZ));
    localparam int C_PULSE = C_QZ + C_DRV;
    localparam int C_REC   = max2(ns_to_cyc(T_WREC_NS, CLK_NS),
                                  ns_to_cyc(T_WC_NS, CLK_NS) - C_PULSE);
    localparam int C_RACC  = max2(ns_to_cyc(T_AA_NS, CLK_NS),
                                  ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int C_MAX   = max2(max2(C_QZ, C_DRV), max2(C_REC, C_RACC));
    localparam int CNT_W   = max2($clog2(C_MAX + 1), 1);
    localparam int SAT_W   = $clog2(C_PULSE + C_REC + 2) + 1;

    localparam logic [CNT_W-1:0] L_QZ   = CNT_W'(C_QZ - 1);
    localparam logic [CNT_W-1:0] L_DRV  = CNT_W'(C_DRV - 1);
    localparam logic [CNT_W-1:0] L_REC  = CNT_W'(C_REC - 1);
    localparam logic [CNT_W-1:0] L_RACC = CNT_W'(C_RACC - 1);

    typedef struct packed {
        asram_st_e         st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic              cs_n;
        logic              ce;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              done;
    } regs_t;

    regs_t            r_d, r_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_last;
    logic             cap_en;
    logic             is_fin;
    logic             take;

    asram_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_dq_i),
        .dout   (resp_rdata)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        t_load    = 1'b0;
        t_val     = '0;
        cap_en    = 1'b0;
        is_fin    = t_last && ((r_q.st == ST_WREC) || (r_q.st == ST_RACC));
        take      = req_valid && ((r_q.st == ST_IDLE) || is_fin);

        if (is_fin) begin
            r_d.done = 1'b1;
            cap_en   = (r_q.st == ST_RACC);
        end

        if (take) begin
            r_d.addr  = req_addr;
            r_d.cs_n  = 1'b0;
            r_d.ce    = 1'b1;
            r_d.dq_oe = 1'b0;
            t_load    = 1'b1;
            if (req_write) begin
                r_d.st   = ST_WFLOAT;
                r_d.wdat = req_wdata;
                r_d.we_n = 1'b0;
                r_d.oe_n = 1'b1;
                t_val    = L_QZ;
            end else if (r_q.st == ST_WREC) begin
                r_d.st   = ST_RTURN;
                r_d.we_n = 1'b1;
                r_d.oe_n = 1'b1;
                t_val    = '0;
            end else begin
                r_d.st   = ST_RACC;
                r_d.we_n = 1'b1;
                r_d.oe_n = 1'b0;
                t_val    = L_RACC;
            end
        end else if (is_fin) begin
            r_d.st    = ST_IDLE;
            r_d.cs_n  = 1'b1;
            r_d.ce    = 1'b0;
            r_d.we_n  = 1'b1;
            r_d.oe_n  = 1'b1;
            r_d.dq_oe = 1'b0;
        end else if (t_last) begin
            case (r_q.st)
                ST_WFLOAT: begin
                    r_d.st    = ST_WDRIVE;
                    r_d.dq_oe = 1'b1;
                    t_load    = 1'b1;
                    t_val     = L_DRV;
                end
                ST_WDRIVE: begin
                    r_d.st    = ST_WREC;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    t_load    = 1'b1;
                    t_val     = L_REC;
                end
                ST_RTURN: begin
                    r_d.st   = ST_RACC;
                    r_d.oe_n = 1'b0;
                    t_load   = 1'b1;
                    t_val    = L_RACC;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.wdat  <= '0;
            r_q.cs_n  <= 1'b1;
            r_q.ce    <= 1'b0;
            r_q.we_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.dq_oe <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign resp_done = r_q.done;
    assign mem_addr  = r_q.addr;
    assign mem_cs_n  = r_q.cs_n;
    assign mem_ce    = r_q.ce;
    assign mem_we_n  = r_q.we_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_dq_o  = r_q.wdat;
    assign mem_dq_oe = r_q.dq_oe;

    // Cycles the write strobe has spent low / high so far (for checks)
    logic [SAT_W-1:0] we_lo_q, we_hi_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_q <= '0;
            we_hi_q <= '1;
        end else begin
            we_lo_q <= (!mem_we_n) ? ((we_lo_q == '1) ? we_lo_q : we_lo_q + 1'b1) : '0;
            we_hi_q <= ( mem_we_n) ? ((we_hi_q == '1) ? we_hi_q : we_hi_q + 1'b1) : '0;
        end
    end

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_we_n)); // R4
    AST_FLOAT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (we_lo_q >= SAT_W'(C_QZ))); // R4
    AST_WRITE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_ce && mem_oe_n)); // R3
    AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr)); // R3
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_q >= SAT_W'(C_PULSE))); // R3
    AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (we_hi_q >= SAT_W'(C_REC))); // R5
    AST_READ_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_ce)); // R2

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + 4) / 5;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int W_QZ    = cyc(9);
    localparam int W_DRV   = mx(cyc(15), mx(cyc(20) - W_QZ, cyc(20) - W_QZ));
    localparam int W_PULSE = W_QZ + W_DRV;
    localparam int W_REC   = mx(cyc(5), cyc(25) - W_PULSE);
    localparam int W_LEN   = W_PULSE + W_REC;
    localparam int W_CYC   = cyc(25);
    localparam int R_ACC   = mx(cyc(25), cyc(9));
    localparam int OE_ACC  = cyc(9);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        resp_done;
    logic [7:0]  resp_rdata;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  ram_q = 8'h00;

    always #2.5 clk = ~clk;

    asram_ctrl u_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_done(resp_done),
        .resp_rdata(resp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(ram_q)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // RAM model and reference
    logic [7:0] ram [0:255];
    logic [7:0] refm [0:255];
    bit         q_rd  [0:7];
    logic [7:0] q_exp [0:7];
    int         q_wp = 0, q_rp = 0;
    logic [7:0] last_rd = 8'h00;
    int         cur_len = 1;
    bit         prev_wr = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i] = 8'h00;
            refm[i] = 8'h00;
        end
    end

    int          addr_age, oe_age, lo_len, hi_len, drv_len, prev_lo;
    bit          seen_wr, moved, prev_done, prev_cs_n;
    logic [14:0] prev_addr, pulse_addr;
    logic [7:0]  wdat;

    always @(negedge clk) begin
        if (!rst_n) begin
            addr_age = 0; oe_age = 0; lo_len = 0; hi_len = 0; drv_len = 0;
            prev_lo = 0; seen_wr = 0; moved = 0; prev_done = 0;
            prev_cs_n = 1; prev_addr = '0; pulse_addr = '0; wdat = '0;
        end else begin
            if (mem_cs_n || !mem_ce) addr_age = 0;
            else if (mem_addr != prev_addr || prev_cs_n) addr_age = 1;
            else if (addr_age < 1000) addr_age++;
            if (mem_oe_n) oe_age = 0; else if (oe_age < 1000) oe_age++;
            if (!mem_cs_n && mem_ce && mem_we_n && !mem_oe_n &&
                addr_age >= R_ACC && oe_age >= OE_ACC)
                ram_q = ram[mem_addr[7:0]];
            else
                ram_q = ~ram[mem_addr[7:0]];

            if (!mem_we_n && !mem_cs_n && mem_ce) begin
                if (lo_len == 0) begin
                    if (seen_wr) begin
                        chk(hi_len >= W_REC, "R5 recovery", hi_len, W_REC);
                        chk(prev_lo + hi_len >= W_CYC, "R5 cycle", prev_lo + hi_len, W_CYC);
                    end
                    pulse_addr = mem_addr;
                end else if (mem_addr != pulse_addr) moved = 1;
                if (mem_dq_oe && drv_len == 0)
                    chk(lo_len >= W_QZ && mem_oe_n, "R4 float", lo_len, W_QZ);
                if (mem_dq_oe) begin
                    drv_len++;
                    wdat = mem_dq_o;
                end
                lo_len++;
                hi_len = 0;
            end else begin
                if (lo_len != 0) begin
                    chk(lo_len == W_PULSE, "R3 pulse", lo_len, W_PULSE);
                    chk(!moved, "R3 addr", moved, 0);
                    chk(drv_len == W_DRV, "R4 drive", drv_len, W_DRV);
                    ram[pulse_addr[7:0]] = wdat;
                    seen_wr = 1; prev_lo = lo_len;
                    lo_len = 0; drv_len = 0; moved = 0;
                end
                if (mem_dq_oe) chk(0, "R4 stray drive", 1, 0);
                if (hi_len < 1000) hi_len++;
            end
            prev_addr = mem_addr;
            prev_cs_n = mem_cs_n;

            if (resp_done) begin
                chk(!prev_done, "R8 width", 2, 1);
                if (q_rp == q_wp) chk(0, "R8 extra done", 1, 0);
                else begin
                    chk(resp_rdata == q_exp[q_rp % 8], q_rd[q_rp % 8] ? "R2 data" : "R8 hold",
                        resp_rdata, q_exp[q_rp % 8]);
                    q_rp++;
                end
            end
            prev_done = resp_done;
        end
    end

    // Present a strobe at a negedge; returns at the negedge of the first access cycle.
    task automatic go(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit b2b);
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        q_rd[q_wp % 8] = !wr;
        if (wr) begin
            refm[a[7:0]] = d;
            q_exp[q_wp % 8] = last_rd;
        end else begin
            q_exp[q_wp % 8] = refm[a[7:0]];
            last_rd = refm[a[7:0]];
        end
        q_wp++;
        cur_len = wr ? W_LEN : ((b2b && prev_wr) ? R_ACC + 1 : R_ACC);
        prev_wr = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle_check(input string req);
        chk(mem_cs_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe, req,
            {mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset levels
        idle_check("R1 reset");
        chk(!resp_done && resp_rdata == 8'h00, "R1 resp", resp_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 idle");

        // Isolated write then read
        go(1'b1, 15'h4A5C, 8'h3C, 1'b0);
        chk(!mem_cs_n && mem_ce && !mem_we_n && mem_oe_n && !mem_dq_oe, "R3 levels",
            {mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b01010);
        repeat (cur_len) @(negedge clk);
        idle_check("R1 after write");
        go(1'b0, 15'h4A5C, 8'h00, 1'b0);
        chk(!mem_cs_n && mem_ce && mem_we_n && !mem_oe_n, "R2 levels",
            {mem_cs_n, mem_ce, mem_we_n, mem_oe_n}, 4'b0110);
        repeat (cur_len) @(negedge clk);

        // Back-to-back: write, write, read (turnaround), read (restart)
        go(1'b1, 15'h0011, 8'hA1, 1'b0);
        repeat (cur_len - 1) @(negedge clk);
        go(1'b1, 15'h7F22, 8'hB2, 1'b1);
        repeat (cur_len - 1) @(negedge clk);
        go(1'b0, 15'h0011, 8'h00, 1'b1);
        chk(!mem_cs_n && mem_oe_n && !mem_dq_oe && mem_we_n, "R6 turnaround",
            {mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b010);
        @(negedge clk);
        chk(!mem_oe_n, "R6 oe after turn", mem_oe_n, 0);
        repeat (cur_len - 2) @(negedge clk);
        go(1'b0, 15'h7F22, 8'h00, 1'b1);
        chk(!mem_cs_n && !mem_oe_n && mem_addr == 15'h7F22, "R7 stay selected",
            mem_addr, 15'h7F22);
        repeat (cur_len) @(negedge clk);

        // Strobe while busy is ignored
        go(1'b1, 15'h0133, 8'h11, 1'b0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0144; req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(mem_addr == 15'h0133 && mem_dq_o == 8'h11 && mem_dq_oe, "R9 ignored",
            {mem_addr, mem_dq_o}, {15'h0133, 8'h11});
        repeat (cur_len - 2) @(negedge clk);
        go(1'b0, 15'h0144, 8'h00, 1'b0);
        repeat (cur_len) @(negedge clk);
        go(1'b0, 15'h0133, 8'h00, 1'b0);
        repeat (cur_len + 2) @(negedge clk);
        chk(q_wp == q_rp, "R9 done count", q_rp, q_wp);

        // Random mix
        cur_len = 1; prev_wr = 1'b0;
        for (int i = 0; i < 300; i++) begin
            bit          wr  = 1'($urandom % 2);
            bit          b2b = ($urandom % 3) != 0;
            logic [14:0] a   = {7'($urandom), 8'($urandom % 24)};
            logic [7:0]  d   = 8'($urandom);
            if (i == 0) b2b = 1'b0;
            if (b2b) repeat (cur_len - 1) @(negedge clk);
            else     repeat (cur_len + int'($urandom % 3)) @(negedge clk);
            go(wr, a, d, b2b);
        end
        repeat (cur_len + 3) @(negedge clk);
        idle_check("R1 final idle");
        chk(q_wp == q_rp, "R8 done count", q_rp, q_wp);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule